// File: doc/BRIEF.md
# Converter Output Offset and Test Pattern Stage

This block sits on the 10-bit sample stream from a converter core, just before the output formatter. In normal operation it adds a small signed digital offset to each valid sample and clamps the result to the 10-bit range. When a test pattern is selected, it replaces the live samples with that pattern. There are seven patterns: three fixed levels, a toggle between all zeros and all ones, two alternating bit patterns, and a user word. The block also re-times the data-valid strobe, whose polarity software can invert.

Samples use offset-binary coding: 10'h000 is the most negative level, 10'h200 is mid scale and 10'h3FF is the most positive level. A byte-wide register port with a synchronous write and a combinational read sets four control registers at addresses 0x12 to 0x15. The output path has one register stage. The toggle pattern is driven by a small state machine with three states. TOG_IDLE means the toggle pattern is not selected and the output is zeros. TOG_ZERO outputs zeros. TOG_ONES outputs ones. The transitions are:
- IDLE→ZERO when the toggle code is selected and no valid sample arrives.
- IDLE→ONES or ZERO→ONES on a valid sample while the toggle code is selected.
- ONES→ZERO on a valid sample.
- Any state→IDLE when another code is selected.

Top module: `adcpat_top`

## Requirements
- R1: After reset, every register field reads zero, `dout` is 10'h000 and `dout_vld` is 0.
- R2: Register map. 0x12 bit 3 is the valid-polarity bit and bits 2:0 are a stored phase code. 0x13 bits 5:0 are the offset. 0x14 bits 2:0 are the pattern code. 0x15 bits 7:0 are user-pattern bits 9:2. Unused bits read as zero. `reg_rdata` reflects `reg_addr` in the same cycle, and a write takes effect at the clock edge.
- R3: Writes to any address other than 0x12 to 0x15 change nothing, and reads from those addresses return 8'h00.
- R4: With pattern code 000, a valid sample plus the two's-complement offset (+31 to −32) appears on `dout` one clock after it is presented.
- R5: The offset sum saturates at 10'h000 and 10'h3FF instead of wrapping.
- R6: Fixed patterns: code 001 gives 10'h200, 010 gives 10'h000, 011 gives 10'h3FF, 110 gives 10'h2AA and 111 gives 10'h155.
- R7: Code 100 outputs 10'h000 on the first valid sample after the code is entered from another code. The output then alternates with 10'h3FF on each valid sample. Cycles without a valid sample do not advance it.
- R8: Code 101 outputs {register 0x15, 2'b00}.
- R9: The offset is never applied to a test pattern.
- R10: `dout_vld` is `smp_vld` delayed one clock and XORed with the polarity bit. `dout` keeps its value on cycles without a valid sample.
- R11: The phase code has no effect on `dout` or `dout_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 10 | Converter sample, offset binary |
| smp_vld | input | 1 | Sample valid |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dout | output | 10 | Output data word |
| dout_vld | output | 1 | Output data-valid with programmable polarity |

## Verification
The hardest case to reach from the ports is the toggle state machine's restart. The bench must show that the sequence starts again at zeros only when the code is re-entered, and that idle cycles between valid samples do not move it. To get there, the bench runs the toggle with gaps in `smp_vld` and checks that the output holds across each gap. It then leaves the code, re-enters it, and checks that the first valid sample gives zeros again. Saturation at both ends is forced with the extreme offsets (+31 and −32) applied to samples near each rail.

// File: rtl/adcpat_pkg.sv
package adcpat_pkg;

    typedef enum logic [2:0] {
        PAT_OFF   = 3'b000,
        PAT_MID   = 3'b001,
        PAT_NEG   = 3'b010,
        PAT_POS   = 3'b011,
        PAT_TOG   = 3'b100,
        PAT_USER  = 3'b101,
        PAT_ALT10 = 3'b110,
        PAT_ALT01 = 3'b111
    } pat_sel_e;

    typedef enum logic [1:0] {
        TOG_IDLE = 2'd0,
        TOG_ZERO = 2'd1,
        TOG_ONES = 2'd2
    } tog_state_e;

    localparam logic [7:0] ADDR_CTRL = 8'h12;
    localparam logic [7:0] ADDR_OFS  = 8'h13;
    localparam logic [7:0] ADDR_PAT  = 8'h14;
    localparam logic [7:0] ADDR_USR  = 8'h15;

endpackage

// File: rtl/adcpat_regs.sv
module adcpat_regs
    import adcpat_pkg::*;
#(
    parameter int OW = 6,
    parameter int UW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          vld_inv,
    output logic [OW-1:0] ofs,
    output pat_sel_e      pat_sel,
    output logic [UW-1:0] usr
);
    logic [2:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_inv <= 1'b0;
            phase_q <= '0;
            ofs     <= '0;
            pat_sel <= PAT_OFF;
            usr     <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_CTRL: begin
                    vld_inv <= wdata[3];
                    phase_q <= wdata[2:0];
                end
                ADDR_OFS: ofs     <= wdata[OW-1:0];
                ADDR_PAT: pat_sel <= pat_sel_e'(wdata[2:0]);
                ADDR_USR: usr     <= wdata[UW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = 8'h00;
        unique case (addr)
            ADDR_CTRL: rdata = {4'b0000, vld_inv, phase_q};
            ADDR_OFS:  rdata[OW-1:0] = ofs;
            ADDR_PAT:  rdata[2:0] = pat_sel;
            ADDR_USR:  rdata[UW-1:0] = usr;
            default:   rdata = 8'h00;
        endcase
    end

    // R2: unused high bits of the control registers always read zero
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_PAT) |-> (rdata[7:3] == 5'b0));

    // R2: a write to the user register is visible in that register next cycle
    assert_usr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_USR) |=> (usr == $past(wdata[UW-1:0])));

    // R3: addresses outside the window read zero
    assert_oob_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < ADDR_CTRL || addr > ADDR_USR) |-> (rdata == 8'h00));

endmodule

// File: rtl/adcpat_offset.sv
module adcpat_offset #(
    parameter int DW = 10,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp,
    input  logic [OW-1:0] ofs,
    output logic [DW-1:0] res
);
    localparam int SW = DW + 2;
    localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

    logic signed [SW-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, smp}) + $signed({{(SW-OW){ofs[OW-1]}}, ofs});
        if (sum < 0)
            res = '0;
        else if (sum > MAXV)
            res = '1;
        else
            res = sum[DW-1:0];
    end

    // R5: a non-negative offset never lowers the sample (no wrap at the top)
    assert_no_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ofs[OW-1] |-> (res >= smp));

    // R5: a negative offset never raises the sample (no wrap at the bottom)
    assert_no_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ofs[OW-1] |-> (res <= smp));

endmodule

// File: rtl/adcpat_patgen.sv
module adcpat_patgen
    import adcpat_pkg::*;
#(
    parameter int DW = 10,
    parameter int UW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pat_sel_e      sel,
    input  logic          vld,
    input  logic [UW-1:0] usr,
    output logic [DW-1:0] pat
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    logic [DW-1:0] alt10;
    tog_state_e    state, state_nx;
    logic [DW-1:0] tog_val;

    for (genvar i = 0; i < DW; i++) begin : g_alt
        assign alt10[i] = (i % 2 == 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TOG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        tog_val  = '0;
        unique case (state)
            TOG_IDLE: begin
                if (sel == PAT_TOG) state_nx = vld ? TOG_ONES : TOG_ZERO;
            end
            TOG_ZERO: begin
                if (sel != PAT_TOG) state_nx = TOG_IDLE;
                else if (vld)       state_nx = TOG_ONES;
            end
            TOG_ONES: begin
                tog_val = '1;
                if (sel != PAT_TOG) state_nx = TOG_IDLE;
                else if (vld)       state_nx = TOG_ZERO;
            end
            default: state_nx = TOG_IDLE;
        endcase
    end

    always_comb begin
        unique case (sel)
            PAT_MID:   pat = MID;
            PAT_NEG:   pat = '0;
            PAT_POS:   pat = '1;
            PAT_TOG:   pat = tog_val;
            PAT_USER:  pat = {usr, {(DW-UW){1'b0}}};
            PAT_ALT10: pat = alt10;
            PAT_ALT01: pat = ~alt10;
            default:   pat = '0;
        endcase
    end

    // R7: the toggle state machine is only active while the toggle code is selected
    assert_tog_only_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != PAT_TOG) |=> (state == TOG_IDLE));

    // R7: a valid sample in the ones state moves the toggle back to zeros
    assert_tog_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TOG_ONES && sel == PAT_TOG && vld) |=> (state == TOG_ZERO));

    // R7: a cycle with no valid sample does not move the toggle
    assert_tog_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TOG_IDLE && sel == PAT_TOG && !vld) |=> $stable(state));

endmodule

// File: rtl/adcpat_top.sv
module adcpat_top
    import adcpat_pkg::*;
#(
    parameter int DW = 10,
    parameter int OW = 6,
    parameter int UW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] smp_in,
    input  logic          smp_vld,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic [DW-1:0] dout,
    output logic          dout_vld
);
    logic          vld_inv;
    logic [OW-1:0] ofs;
    pat_sel_e      pat_sel;
    logic [UW-1:0] usr;
    logic [DW-1:0] live_val;
    logic [DW-1:0] pat_val;

    adcpat_regs #(.OW(OW), .UW(UW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .vld_inv (vld_inv),
        .ofs     (ofs),
        .pat_sel (pat_sel),
        .usr     (usr)
    );

    adcpat_offset #(.DW(DW), .OW(OW)) u_ofs (
        .clk   (clk),
        .rst_n (rst_n),
        .smp   (smp_in),
        .ofs   (ofs),
        .res   (live_val)
    );

    adcpat_patgen #(.DW(DW), .UW(UW)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (pat_sel),
        .vld   (smp_vld),
        .usr   (usr),
        .pat   (pat_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= smp_vld ^ vld_inv;
            if (smp_vld)
                dout <= (pat_sel == PAT_OFF) ? live_val : pat_val;
        end
    end

    // R4: with no pattern and zero offset a valid sample passes straight through
    assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == PAT_OFF && ofs == '0 && smp_vld) |=> (dout == $past(smp_in)));

    // R10: output data holds on cycles without a valid sample
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(dout));

    // R10: with normal polarity the strobe follows the input valid one cycle later
    assert_vld_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_inv && smp_vld) |=> dout_vld);

    // R9: a fixed mid-scale pattern ignores the offset
    assert_pat_no_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == PAT_MID && smp_vld) |=> (dout == (DW'(1) << (DW - 1))));

endmodule

// File: tb/tb_adcpat_top.sv
module tb_adcpat_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] smp_in = '0;
    logic       smp_vld = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [9:0] dout;
    logic       dout_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adcpat_top dut (
        .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dout(dout), .dout_vld(dout_vld)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic send(logic [9:0] s, logic v);
        smp_in = s; smp_vld = v;
        @(posedge clk); #1;
    endtask

    function automatic int sat(int s, int o);
        int r = s + o;
        if (r < 0) r = 0;
        if (r > 1023) r = 1023;
        return r;
    endfunction

    task automatic t_reset();
        chk("R1 dout", dout, 0);
        chk("R1 dout_vld", dout_vld, 0);
        for (int a = 8'h12; a <= 8'h15; a++) rd_chk("R1 reg", 8'(a), 8'h00);
    endtask

    task automatic t_regs();
        wr(8'h12, 8'hF7); rd_chk("R2 ctrl", 8'h12, 8'h07);
        wr(8'h13, 8'hFF); rd_chk("R2 ofs", 8'h13, 8'h3F);
        wr(8'h14, 8'hFD); rd_chk("R2 pat", 8'h14, 8'h05);
        wr(8'h15, 8'hA5); rd_chk("R2 usr", 8'h15, 8'hA5);
        wr(8'h16, 8'h55); wr(8'h11, 8'h55); wr(8'h00, 8'h55);
        rd_chk("R3 oob16", 8'h16, 8'h00);
        rd_chk("R3 oob11", 8'h11, 8'h00);
        rd_chk("R3 keep12", 8'h12, 8'h07);
        rd_chk("R3 keep13", 8'h13, 8'h3F);
        rd_chk("R3 keep14", 8'h14, 8'h05);
        rd_chk("R3 keep15", 8'h15, 8'hA5);
        wr(8'h12, 8'h00); wr(8'h13, 8'h00); wr(8'h14, 8'h00);
    endtask

    task automatic t_offset();
        send(10'h155, 1'b1); chk("R4 zero ofs", dout, 'h155);
        wr(8'h13, 8'h1F);
        send(10'd100, 1'b1);  chk("R4 +31", dout, sat(100, 31));
        send(10'd1000, 1'b1); chk("R5 top sat", dout, 1023);
        wr(8'h13, 8'h20);
        send(10'd500, 1'b1);  chk("R4 -32", dout, sat(500, -32));
        send(10'd10, 1'b1);   chk("R5 bottom sat", dout, 0);
        wr(8'h13, 8'h3D);
        send(10'd40, 1'b1);   chk("R4 -3", dout, sat(40, -3));
    endtask

    task automatic t_patterns();
        wr(8'h13, 8'h1F);
        wr(8'h15, 8'hA5);
        wr(8'h14, 8'h01); send(10'd7, 1'b1); chk("R6 R9 mid", dout, 'h200);
        wr(8'h14, 8'h02); send(10'd7, 1'b1); chk("R6 R9 neg", dout, 'h000);
        wr(8'h14, 8'h03); send(10'd7, 1'b1); chk("R6 pos", dout, 'h3FF);
        wr(8'h14, 8'h06); send(10'd7, 1'b1); chk("R6 alt10", dout, 'h2AA);
        wr(8'h14, 8'h07); send(10'd7, 1'b1); chk("R6 alt01", dout, 'h155);
        wr(8'h14, 8'h05); send(10'd7, 1'b1); chk("R8 R9 user", dout, 'h294);
        wr(8'h14, 8'h00); wr(8'h13, 8'h00);
    endtask

    task automatic t_toggle();
        wr(8'h14, 8'h04);
        send(10'd9, 1'b1); chk("R7 first", dout, 'h000);
        send(10'd9, 1'b1); chk("R7 second", dout, 'h3FF);
        send(10'd9, 1'b0); chk("R7 R10 hold", dout, 'h3FF);
        send(10'd9, 1'b0); chk("R7 hold2", dout, 'h3FF);
        send(10'd9, 1'b1); chk("R7 third", dout, 'h000);
        send(10'd9, 1'b1); chk("R7 fourth", dout, 'h3FF);
        wr(8'h14, 8'h00);
        send(10'd9, 1'b1); chk("R7 leave", dout, 'h009);
        wr(8'h14, 8'h04);
        send(10'd9, 1'b1); chk("R7 restart", dout, 'h000);
        wr(8'h14, 8'h00);
    endtask

    task automatic t_valid();
        send(10'd33, 1'b1); chk("R10 vld norm", dout_vld, 1);
        send(10'd44, 1'b0); chk("R10 novld norm", dout_vld, 0);
        chk("R10 data hold", dout, 33);
        wr(8'h12, 8'h08);
        send(10'd55, 1'b1); chk("R10 vld inv", dout_vld, 0);
        send(10'd55, 1'b0); chk("R10 novld inv", dout_vld, 1);
        wr(8'h12, 8'h0F);
        send(10'd66, 1'b1); chk("R11 phase data", dout, 66);
        chk("R11 phase vld", dout_vld, 0);
        wr(8'h12, 8'h07);
        send(10'd77, 1'b1); chk("R11 phase norm", dout_vld, 1);
        chk("R11 phase data2", dout, 77);
        wr(8'h12, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_offset();
        t_patterns();
        t_toggle();
        t_valid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule